// File: doc/BRIEF.md
# Memory Bandwidth Monitor Counter

This block observes the request and grant strobes of a memory controller's arbitrated ports and measures how busy they are over a programmable window of clock cycles. Every cycle that carries at least one request, or at least one grant, adds one to a free-running total. Two monitor channels each add one for every cycle in which a grant passes that channel's filter. Each counted grant cycle stands for one fixed-size data beat, so all counts are in cycles; software converts them to bytes.

A channel's filter has two parts: a port mask that selects arbitrated ports, and a subport mask. The subport mask only applies to one shared device port, which is split by a subport identifier input. When the window closes, the live counts are copied into read-only totals and the live counters restart from zero. An interrupt flag is then raised and the monitor disarms itself. Software reads the totals, clears the flag by writing one to it, and writes the enable bit again to start the next window.

Top module: `bwm_top`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `rd_data_o` is zero.
- R2: The register map uses word addresses. Control is at 0, with bit 31 as enable, bit 20 as window mode, bit 16 as the interrupt flag, and bits 1:0 as the channel enables. The window length is at 1. Channel c has its port mask at 2+2c and its subport mask at 3+2c. `rd_data_o` shows the register at `rd_addr_i` one cycle later. Unmapped addresses read zero.
- R3: With enable and window mode both set, the window closes after `timer` counted cycles, and a timer of 0 acts as 1. If the arming write takes effect at clock edge k, the flag rises after edge k+timer. When it rises, the enable bit reads 0.
- R4: Totals are read at address 6 (request cycles) and address 7 (grant cycles). They count cycles with any request bit set, or any grant bit set, during the window.
- R5: Channel c counts a grant on port p when bit p of its port mask is set and bit c of the channel enables is set. A channel whose enable is clear counts nothing. Channel totals are read at 8 and 9.
- R6: A grant on the shared device port (port 4) counts only if the subport mask bit selected by `sub_id_i` is also set. With a subport mask of 0xFF, port 4 behaves like any other port.
- R7: Once the flag is set, the totals keep their values while traffic continues.
- R8: Writing control with bit 16 set clears the flag. While the flag is set, nothing is counted, even if the enable bit is written again.
- R9: Counters saturate at all ones instead of wrapping.
- R10: With window mode clear, no window closes and the flag stays low.
- R11: A channel counts cycles, not grants. Several qualifying grants in one cycle add one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NPORT | Request strobe per arbitrated port |
| gnt_i | input | NPORT | Grant strobe per arbitrated port |
| sub_id_i | input | SUB_W | Subport identifier for the shared device port |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | AW | Register read word address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Window-complete interrupt |

## Verification
On every cycle, the assertions check four things: the monitor disarms when the flag rises, the totals hold while the flag is set, no channel total exceeds the all-grant total, and a saturated counter stays saturated. They also check that a one written to the flag bit clears it. Other behaviour can only be shown by the directed scenarios. These scenarios cover the exact window length measured in cycles, mask and subport filtering, counting once per cycle when several grants coincide, the zero-length timer, and re-arming a second window. They also cover disarming, keeping the flag low when window mode is off, and saturation over a window longer than the counter's range.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int A_CTRL      = 0;
  localparam int A_TIMER     = 1;
  localparam int A_MASK_BASE = 2;
  localparam int EN_BIT      = 31;
  localparam int TMODE_BIT   = 20;
  localparam int IRQ_BIT     = 16;
endpackage

// File: rtl/bwm_satcnt.sv
module bwm_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = cnt;
    if (inc && (cnt != {W{1'b1}})) nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= nxt;
  end
endmodule

// File: rtl/bwm_filter.sv
module bwm_filter #(
  parameter int NPORT    = 8,
  parameter int DEV_PORT = 4,
  parameter int SUB_W    = 3,
  localparam int SMW     = 1 << SUB_W
) (
  input  logic [NPORT-1:0] gnt,
  input  logic [NPORT-1:0] pmask,
  input  logic [SMW-1:0]   smask,
  input  logic [SUB_W-1:0] sub_id,
  output logic             hit
);
  logic [NPORT-1:0] qual;
  always_comb begin
    qual = gnt & pmask;
    qual[DEV_PORT] = qual[DEV_PORT] & smask[sub_id];
    hit = |qual;
  end
endmodule

// File: rtl/bwm_window.sv
module bwm_window #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             active,
  input  logic             tmode,
  input  logic [TMR_W-1:0] timer,
  output logic             done
);
  logic [TMR_W-1:0] wcnt;
  logic [TMR_W:0]   wnext;

  assign wnext = {1'b0, wcnt} + 1'b1;
  assign done  = active && tmode && (wnext >= {1'b0, timer});

  always_ff @(posedge clk) begin
    if (rst || start || done)  wcnt <= '0;
    else if (active && tmode)  wcnt <= wnext[TMR_W-1:0];
  end
endmodule

// File: rtl/bwm_top.sv
module bwm_top
  import bwm_pkg::*;
#(
  parameter int NPORT    = 8,
  parameter int DEV_PORT = 4,
  parameter int SUB_W    = 3,
  parameter int NCH      = 2,
  parameter int CNT_W    = 32,
  parameter int TMR_W    = 32,
  parameter int AW       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] req_i,
  input  logic [NPORT-1:0] gnt_i,
  input  logic [SUB_W-1:0] sub_id_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [31:0]      wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [31:0]      rd_data_o,
  output logic             irq_o
);
  localparam int SMW   = 1 << SUB_W;
  localparam int A_TOT = A_MASK_BASE + 2 * NCH;

  logic             ctrl_en, ctrl_tmode, irq_q;
  logic [NCH-1:0]   ctrl_chen;
  logic [TMR_W-1:0] timer_q;
  logic [NPORT-1:0] pmask_q [NCH];
  logic [SMW-1:0]   smask_q [NCH];

  logic wr_ctrl, active, start, win_done, clr;

  assign wr_ctrl = wr_en_i && (wr_addr_i == AW'(A_CTRL));
  assign active  = ctrl_en && !irq_q;
  assign start   = wr_ctrl && wr_data_i[EN_BIT] && !ctrl_en;
  assign clr     = start || win_done;

  bwm_window #(.TMR_W(TMR_W)) u_win (
    .clk(clk), .rst(rst), .start(start), .active(active),
    .tmode(ctrl_tmode), .timer(timer_q), .done(win_done)
  );

  logic [CNT_W-1:0] live_req, nxt_req, live_gnt, nxt_gnt;
  logic [CNT_W-1:0] snap_req, snap_gnt;
  logic [NCH-1:0][CNT_W-1:0] live_ch, nxt_ch, snap_ch;

  bwm_satcnt #(.W(CNT_W)) u_req (
    .clk(clk), .rst(rst), .clr(clr), .inc(active && (|req_i)),
    .cnt(live_req), .nxt(nxt_req)
  );
  bwm_satcnt #(.W(CNT_W)) u_gnt (
    .clk(clk), .rst(rst), .clr(clr), .inc(active && (|gnt_i)),
    .cnt(live_gnt), .nxt(nxt_gnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    bwm_filter #(.NPORT(NPORT), .DEV_PORT(DEV_PORT), .SUB_W(SUB_W)) u_flt (
      .gnt(gnt_i), .pmask(pmask_q[c]), .smask(smask_q[c]),
      .sub_id(sub_id_i), .hit(hit)
    );
    bwm_satcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr), .inc(active && ctrl_chen[c] && hit),
      .cnt(live_ch[c]), .nxt(nxt_ch[c])
    );
  end

  // totals captured at window close
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_req <= '0;
      snap_gnt <= '0;
      snap_ch  <= '0;
    end else if (win_done) begin
      snap_req <= nxt_req;
      snap_gnt <= nxt_gnt;
      snap_ch  <= nxt_ch;
    end
  end

  // control and configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ctrl_tmode <= 1'b0;
      ctrl_chen  <= '0;
      irq_q      <= 1'b0;
      timer_q    <= '0;
      for (int c = 0; c < NCH; c++) begin
        pmask_q[c] <= '0;
        smask_q[c] <= '0;
      end
    end else begin
      if (wr_ctrl) begin
        ctrl_en    <= wr_data_i[EN_BIT];
        ctrl_tmode <= wr_data_i[TMODE_BIT];
        ctrl_chen  <= wr_data_i[NCH-1:0];
      end
      if (win_done) ctrl_en <= 1'b0;
      if (win_done)                             irq_q <= 1'b1;
      else if (wr_ctrl && wr_data_i[IRQ_BIT])   irq_q <= 1'b0;
      if (wr_en_i && wr_addr_i == AW'(A_TIMER)) timer_q <= wr_data_i[TMR_W-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (wr_en_i && wr_addr_i == AW'(A_MASK_BASE + 2 * c))
          pmask_q[c] <= wr_data_i[NPORT-1:0];
        if (wr_en_i && wr_addr_i == AW'(A_MASK_BASE + 2 * c + 1))
          smask_q[c] <= wr_data_i[SMW-1:0];
      end
    end
  end

  // read mux, registered
  logic [31:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    if (rd_addr_i == AW'(A_CTRL)) begin
      rd_nxt[EN_BIT]    = ctrl_en;
      rd_nxt[TMODE_BIT] = ctrl_tmode;
      rd_nxt[IRQ_BIT]   = irq_q;
      rd_nxt[NCH-1:0]   = ctrl_chen;
    end
    if (rd_addr_i == AW'(A_TIMER))   rd_nxt = 32'(timer_q);
    if (rd_addr_i == AW'(A_TOT))     rd_nxt = 32'(snap_req);
    if (rd_addr_i == AW'(A_TOT + 1)) rd_nxt = 32'(snap_gnt);
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr_i == AW'(A_MASK_BASE + 2 * c))     rd_nxt = 32'(pmask_q[c]);
      if (rd_addr_i == AW'(A_MASK_BASE + 2 * c + 1)) rd_nxt = 32'(smask_q[c]);
      if (rd_addr_i == AW'(A_TOT + 2 + c))           rd_nxt = 32'(snap_ch[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_nxt;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/bwm_chk.sv
module bwm_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 32,
  parameter int AW    = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      irq_o,
  input logic                      ctrl_en,
  input logic                      win_done,
  input logic                      clr,
  input logic                      wr_en_i,
  input logic [AW-1:0]             wr_addr_i,
  input logic [31:0]               wr_data_i,
  input logic [CNT_W-1:0]          snap_gnt,
  input logic [CNT_W-1:0]          live_gnt,
  input logic [NCH-1:0][CNT_W-1:0] snap_ch
);
  AST_IRQ_DISARMS: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> !ctrl_en); // R3

  AST_TOTALS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(irq_o)) |-> $stable(snap_gnt)); // R7

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (live_gnt == {CNT_W{1'b1}} && !clr) |=> (live_gnt == {CNT_W{1'b1}})); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == '0 && wr_data_i[16] && !win_done) |=> !irq_o); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_CH_LE_ALL: assert property (@(posedge clk) disable iff (rst)
      snap_ch[c] <= snap_gnt); // R5
  end
endmodule

bind bwm_top bwm_chk #(.NCH(NCH), .CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .ctrl_en(ctrl_en),
  .win_done(win_done), .clr(clr), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .snap_gnt(snap_gnt), .live_gnt(live_gnt),
  .snap_ch(snap_ch)
);

// File: tb/tb_bwm_top.sv
`timescale 1ns/1ps
module tb_bwm_top;
  localparam int NPORT = 8, SUB_W = 3, AW = 4, CNT_W = 8;
  localparam logic [31:0] EN = 32'h8000_0000, TM = 32'h0010_0000, CLR = 32'h0001_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [NPORT-1:0] req_i = '0, gnt_i = '0;
  logic [SUB_W-1:0] sub_id_i = '0;
  logic wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic irq_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  bwm_top #(.NPORT(NPORT), .SUB_W(SUB_W), .CNT_W(CNT_W), .AW(AW)) dut (
    .clk(clk), .rst(rst), .req_i(req_i), .gnt_i(gnt_i), .sub_id_i(sub_id_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr_i = AW'(a);
    @(posedge clk);
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  // arm then count negedges until the flag rises
  task automatic arm_wait(input logic [31:0] chen, input int exp_len, input string tag);
    int n = 0;
    wr(0, EN | TM | chen);
    while (!irq_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, n, exp_len);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq_o, 0);
    chk("R1 rdata", rd_data_o, 0);
    rdchk("R1 ctrl", 0, 0);
    rdchk("R1 timer", 1, 0);
    rdchk("R1 grant total", 7, 0);
    rdchk("R1 ch1 total", 9, 0);
  endtask

  task automatic t_regs;
    wr(1, 10); wr(2, 32'h03); wr(3, 32'hFF); wr(4, 32'h10); wr(5, 32'h04);
    rdchk("R2 timer", 1, 10);
    rdchk("R2 pmask1", 4, 32'h10);
    rdchk("R2 smask1", 5, 32'h04);
    rdchk("R2 unmapped", 15, 0);
  endtask

  task automatic t_main;
    req_i = 8'hFF; gnt_i = 8'h03; sub_id_i = 3'd2;
    arm_wait(3, 10, "R3 window length");
    req_i = '0; gnt_i = '0;
    rdchk("R3 ctrl after close", 0, TM | CLR | 3);
    rdchk("R4 request total", 6, 10);
    rdchk("R4 grant total", 7, 10);
    rdchk("R11 ch0 one per cycle", 8, 10);
    rdchk("R5 ch1 unmasked port", 9, 0);
    wr(0, CLR);
    chk("R8 flag cleared", irq_o, 0);
  endtask

  task automatic t_sub;
    wr(1, 7);
    gnt_i = 8'h10; sub_id_i = 3'd2;
    arm_wait(3, 7, "R3 second window");
    gnt_i = '0;
    rdchk("R6 ch1 subport hit", 9, 7);
    rdchk("R5 ch0 port4 masked", 8, 0);
    wr(0, CLR);
    gnt_i = 8'h10; sub_id_i = 3'd3;
    arm_wait(3, 7, "R3 third window");
    gnt_i = '0;
    rdchk("R6 ch1 subport miss", 9, 0);
    rdchk("R6 grant total", 7, 7);
    wr(0, CLR);
    gnt_i = 8'h10; sub_id_i = 3'd2;
    arm_wait(1, 7, "R3 fourth window");
    gnt_i = '0;
    rdchk("R5 ch1 disabled", 9, 0);
    wr(0, CLR);
  endtask

  task automatic t_req_only;
    req_i = 8'h20;
    arm_wait(3, 7, "R3 req window");
    req_i = '0;
    rdchk("R4 request only", 6, 7);
    rdchk("R4 no grant", 7, 0);
  endtask

  task automatic t_hold_block;
    logic [31:0] d;
    gnt_i = 8'hFF; req_i = 8'hFF;
    repeat (20) @(negedge clk);
    rdchk("R7 request total held", 6, 7);
    rdchk("R7 grant total held", 7, 0);
    wr(0, EN | TM | 3);
    repeat (15) @(negedge clk);
    chk("R8 flag still set", irq_o, 1);
    rd(7, d);
    chk("R8 no count while flagged", d, 0);
    gnt_i = '0; req_i = '0;
    wr(0, CLR);
    chk("R8 flag clear", irq_o, 0);
    rdchk("R8 ctrl flag bit", 0, 0);
  endtask

  task automatic t_timer0;
    wr(1, 0);
    gnt_i = 8'h01;
    arm_wait(3, 1, "R3 zero timer acts as one");
    gnt_i = '0;
    rdchk("R3 zero timer count", 7, 1);
    wr(0, CLR);
  endtask

  task automatic t_notimer;
    gnt_i = 8'h01;
    wr(0, EN | 3);
    repeat (30) @(negedge clk);
    chk("R10 no flag without window mode", irq_o, 0);
    rdchk("R10 totals untouched", 7, 1);
    wr(0, 0);
    gnt_i = '0;
  endtask

  task automatic t_sat;
    wr(1, 300);
    gnt_i = 8'h01;
    arm_wait(3, 300, "R3 long window");
    gnt_i = '0;
    rdchk("R9 grant saturates", 7, 255);
    rdchk("R9 ch0 saturates", 8, 255);
    wr(0, CLR);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_regs;
    t_main;
    t_sub;
    t_req_only;
    t_hold_block;
    t_timer0;
    t_notimer;
    t_sat;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule